// File: doc/BRIEF.md
# Interrupt-Driven Transfer Chain Sequencer

This block is a small data-transfer engine that a single activation request sets running. On each activation it fetches a three-word parameter set from memory (a header word carrying a mode byte and a 16-bit remaining count, then a source address word and a destination address word). It copies one data word from the source to the destination and writes the header back with the count lowered by one. Three bits of the mode byte decide what follows. The engine can load the parameter set held in the next fixed-size slot and move another word without a new request. It can instead stop and wait for the next activation. They also decide whether the requesting source's pending flag is cleared, whether its activation enable is cleared, and whether the CPU is interrupted.

The FSM has six named states. `ST_IDLE` waits for a request. `ST_READ_INFO` reads the three words of the parameter set. `ST_READ_DATA` reads the source word. `ST_WRITE_DATA` stores it at the destination. `ST_WRITEBACK` stores the updated header. `ST_DECIDE` issues the end-of-step pulses for one cycle. The transitions are:
- `ST_IDLE -> ST_READ_INFO` on a request.
- `ST_READ_INFO -> ST_READ_DATA` after the third word is accepted.
- `ST_READ_DATA -> ST_WRITE_DATA`, `ST_WRITE_DATA -> ST_WRITEBACK` and `ST_WRITEBACK -> ST_DECIDE`, each on its handshake.
- `ST_DECIDE -> ST_READ_INFO` when chaining, with the slot address advanced.
- `ST_DECIDE -> ST_IDLE` otherwise.

Every memory access uses a valid/ready handshake. Read data is taken in the same cycle as ready.

Top module: `xfer_chain_seq`

## Requirements
- R1: While reset is held, `busy`, `mem_valid`, `flag_clr`, `irq_req` and `en_clr` are all low.
- R2: An activation performs, in this order: reads of the header, source and destination words at `act_base`, `act_base+1` and `act_base+2`; a read at the source address; a write of that data to the destination address; and a write to `act_base` of the header with bits 31..16 unchanged and bits 15..0 equal to the old count minus one (modulo 2^16).
- R3: When header bit 31 (chain enable) is 0, the step ends: after the pulse cycle `busy` is low and no memory access is issued until the next request.
- R4: When header bit 31 is 1 and bit 29 (chain select) is 0, the engine always continues with the parameter set at base plus `SLOT_WORDS` (4 by default) and repeats the R2 sequence there.
- R5: When bits 31 and 29 are both 1, the engine continues with the next slot only if the written-back count is 0. Otherwise the step ends with normal end handling.
- R6: A step that continues to the next slot raises none of `flag_clr`, `en_clr` or `irq_req`.
- R7: When a step ends with a nonzero count and header bit 30 (interrupt select) is 0, `flag_clr` pulses and `irq_req` stays low.
- R8: When a step ends with a count of 0, `en_clr` and `irq_req` pulse together and `flag_clr` stays low, whatever bit 30 holds.
- R9: When a step ends with a nonzero count and bit 30 is 1, `irq_req` pulses and `flag_clr` stays low.
- R10: Header bits 28..24 have no effect on sequencing or pulses, and they are written back unchanged.
- R11: A request that arrives while `busy` is high is dropped and leaves no trace in the access sequence.
- R12: A pending access holds its address, direction and write data until ready. The end-of-step pulses last one cycle, fall in the cycle right after the header write-back handshake, and carry the latched source number on `evt_src`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_req | input | 1 | Activation request, sampled while idle |
| act_src | input | SRC_W | Number of the requesting source |
| act_base | input | AW | Word address of the first parameter set |
| mem_valid | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Word address of the access |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Access accepted this cycle |
| mem_rdata | input | DW | Read data, valid with ready |
| busy | output | 1 | High whenever the FSM is not in `ST_IDLE` |
| flag_clr | output | 1 | One-cycle pulse: clear the requesting source's pending flag |
| irq_req | output | 1 | One-cycle pulse: interrupt the CPU |
| en_clr | output | 1 | One-cycle pulse: clear the requesting source's activation enable |
| evt_src | output | SRC_W | Source number tied to the pulses |

## Verification
Each access completes on the edge where valid and ready are both high, so the bench pops its expected access at the handshake it sees, whatever stalls the ready pattern adds. The end-of-step pulses are due exactly one cycle after the header write-back handshake. With ready held high, that is seven edges after the request is sampled. The bench arms its pulse check on that handshake and compares the pulses one cycle later; in every other cycle it expects all three pulses to be low. Idle behaviour after an ending step, and after a request dropped while busy, is checked a few cycles after the access queue drains.

// File: rtl/xcs_pkg.sv
package xcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_INFO,
        ST_READ_DATA,
        ST_WRITE_DATA,
        ST_WRITEBACK,
        ST_DECIDE
    } xcs_state_e;

    localparam int MODE_W         = 8;
    localparam int MODE_CHAIN_EN  = 7;
    localparam int MODE_INT_SEL   = 6;
    localparam int MODE_CHAIN_SEL = 5;

endpackage

// File: rtl/xcs_info_regs.sv
module xcs_info_regs #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int CW    = 16,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic [DW-1:0]    rdata,
    input  logic             cnt_wr_en,
    input  logic [CW-1:0]    cnt_wr_val,
    output logic [DW-CW-1:0] hdr_hi,
    output logic [CW-1:0]    cnt,
    output logic [AW-1:0]    src_addr,
    output logic [AW-1:0]    dst_addr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_hi   <= '0;
            cnt      <= '0;
            src_addr <= '0;
            dst_addr <= '0;
        end else begin
            if (cap_en) begin
                case (cap_idx)
                    IDX_W'(0): begin
                        hdr_hi <= rdata[DW-1:CW];
                        cnt    <= rdata[CW-1:0];
                    end
                    IDX_W'(1): src_addr <= rdata[AW-1:0];
                    IDX_W'(2): dst_addr <= rdata[AW-1:0];
                    default: ;
                endcase
            end
            if (cnt_wr_en) begin
                cnt <= cnt_wr_val;
            end
        end
    end

endmodule

// File: rtl/xcs_chain_decide.sv
module xcs_chain_decide #(
    parameter int CW = 16
) (
    input  logic          chain_en,
    input  logic          int_sel,
    input  logic          chain_sel,
    input  logic [CW-1:0] cnt_new,
    output logic          chain_go,
    output logic          pulse_flag,
    output logic          pulse_irq,
    output logic          pulse_en
);

    logic cnt_zero;

    always_comb begin
        cnt_zero   = (cnt_new == '0);
        chain_go   = chain_en && (!chain_sel || cnt_zero);
        pulse_flag = 1'b0;
        pulse_irq  = 1'b0;
        pulse_en   = 1'b0;
        if (!chain_go) begin
            pulse_en   = cnt_zero;
            pulse_irq  = cnt_zero || int_sel;
            pulse_flag = !cnt_zero && !int_sel;
        end
    end

endmodule

// File: rtl/xfer_chain_seq.sv
module xfer_chain_seq
    import xcs_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int CW         = 16,
    parameter int SRC_W      = 4,
    parameter int SLOT_WORDS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_req,
    input  logic [SRC_W-1:0] act_src,
    input  logic [AW-1:0]    act_base,
    output logic             mem_valid,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ready,
    input  logic [DW-1:0]    mem_rdata,
    output logic             busy,
    output logic             flag_clr,
    output logic             irq_req,
    output logic             en_clr,
    output logic [SRC_W-1:0] evt_src
);

    localparam int HI_W       = DW - CW;
    localparam int INFO_WORDS = 3;
    localparam int IDX_W      = $clog2(INFO_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(INFO_WORDS - 1);

    xcs_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [AW-1:0]     base_q;
    logic [SRC_W-1:0]  src_q;
    logic [DW-1:0]     data_q;

    logic              hs;
    logic [HI_W-1:0]   hdr_hi;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     cnt_dec;
    logic [AW-1:0]     src_addr;
    logic [AW-1:0]     dst_addr;
    logic [MODE_W-1:0] mode;
    logic              chain_go, d_flag, d_irq, d_en;
    logic              cap_en, cnt_wr_en;

    assign hs        = mem_valid && mem_ready;
    assign cnt_dec   = cnt - CW'(1);
    assign mode      = hdr_hi[HI_W-1 -: MODE_W];
    assign cap_en    = (state_q == ST_READ_INFO) && hs;
    assign cnt_wr_en = (state_q == ST_WRITEBACK) && hs;

    xcs_info_regs #(
        .AW   (AW),
        .DW   (DW),
        .CW   (CW),
        .IDX_W(IDX_W)
    ) u_info (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .cap_idx   (idx_q),
        .rdata     (mem_rdata),
        .cnt_wr_en (cnt_wr_en),
        .cnt_wr_val(cnt_dec),
        .hdr_hi    (hdr_hi),
        .cnt       (cnt),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr)
    );

    xcs_chain_decide #(
        .CW(CW)
    ) u_decide (
        .chain_en  (mode[MODE_CHAIN_EN]),
        .int_sel   (mode[MODE_INT_SEL]),
        .chain_sel (mode[MODE_CHAIN_SEL]),
        .cnt_new   (cnt),
        .chain_go  (chain_go),
        .pulse_flag(d_flag),
        .pulse_irq (d_irq),
        .pulse_en  (d_en)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (act_req) state_d = ST_READ_INFO;
            ST_READ_INFO:  if (hs && idx_q == LAST_IDX) state_d = ST_READ_DATA;
            ST_READ_DATA:  if (hs) state_d = ST_WRITE_DATA;
            ST_WRITE_DATA: if (hs) state_d = ST_WRITEBACK;
            ST_WRITEBACK:  if (hs) state_d = ST_DECIDE;
            ST_DECIDE:     state_d = chain_go ? ST_READ_INFO : ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State register and step context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            base_q  <= '0;
            src_q   <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && act_req) begin
                base_q <= act_base;
                src_q  <= act_src;
                idx_q  <= '0;
            end
            if (cap_en) begin
                idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + IDX_W'(1);
            end
            if (state_q == ST_READ_DATA && hs) begin
                data_q <= mem_rdata;
            end
            if (state_q == ST_DECIDE && chain_go) begin
                base_q <= base_q + AW'(SLOT_WORDS);
                idx_q  <= '0;
            end
        end
    end

    // Outputs
    always_comb begin
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        flag_clr  = 1'b0;
        irq_req   = 1'b0;
        en_clr    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_READ_INFO: begin
                mem_valid = 1'b1;
                mem_addr  = base_q + AW'(idx_q);
            end
            ST_READ_DATA: begin
                mem_valid = 1'b1;
                mem_addr  = src_addr;
            end
            ST_WRITE_DATA: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_addr;
                mem_wdata = data_q;
            end
            ST_WRITEBACK: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = base_q;
                mem_wdata = {hdr_hi, cnt_dec};
            end
            ST_DECIDE: begin
                flag_clr = d_flag;
                irq_req  = d_irq;
                en_clr   = d_en;
            end
            default: ;
        endcase
    end

    assign busy    = (state_q != ST_IDLE);
    assign evt_src = src_q;

endmodule

// File: rtl/xcs_chk.sv
module xcs_chk #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          act_req,
    input logic          busy,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          flag_clr,
    input logic          irq_req,
    input logic          en_clr
);

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R12

    AST_NO_ACCESS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_valid); // R3

    AST_START_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(act_req)); // R11

    AST_PULSE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req || flag_clr || en_clr) |-> $past(mem_valid && mem_ready && mem_we)); // R12

    AST_ENCLR_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |-> irq_req); // R8

    AST_FLAG_NOT_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_clr && irq_req)); // R7

    AST_FLAG_EN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_clr, en_clr})); // R8

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req || flag_clr) |=> !(irq_req || flag_clr)); // R12

endmodule

bind xfer_chain_seq xcs_chk #(
    .AW(AW),
    .DW(DW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_req  (act_req),
    .busy     (busy),
    .mem_valid(mem_valid),
    .mem_ready(mem_ready),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .flag_clr (flag_clr),
    .irq_req  (irq_req),
    .en_clr   (en_clr)
);

// File: tb/xfer_chain_seq_tb.sv
`timescale 1ns/1ps
module xfer_chain_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        act_req;
    logic [3:0]  act_src;
    logic [15:0] act_base;
    logic        mem_valid, mem_we, mem_ready;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        busy, flag_clr, irq_req, en_clr;
    logic [3:0]  evt_src;

    always #2.5 clk = ~clk;

    logic [31:0] mem [0:255];
    assign mem_rdata = mem[mem_addr[7:0]];

    xfer_chain_seq u_dut (
        .clk(clk), .rst_n(rst_n), .act_req(act_req), .act_src(act_src), .act_base(act_base),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .busy(busy), .flag_clr(flag_clr),
        .irq_req(irq_req), .en_clr(en_clr), .evt_src(evt_src)
    );

    typedef struct packed {
        logic        we;
        logic        wb;
        logic [15:0] addr;
        logic [31:0] data;
    } acc_t;

    acc_t        acc_q[$];
    string       acc_tag_q[$];
    logic [2:0]  ev_q[$];
    string       ev_tag_q[$];
    string       tag_force = "";
    logic [3:0]  exp_src;
    logic        decide_due = 1'b0;
    logic        rdy_rand = 1'b0;
    logic [7:0]  lfsr = 8'hA5;
    logic [31:0] sh [0:255];
    int          checks = 0;
    int          fails = 0;
    bit          finished = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural model: builds the expected access and pulse sequence of one activation
    task automatic build(input logic [15:0] base);
        logic [7:0]  b;
        logic [31:0] w0, w1, w2, d, nw0;
        logic [15:0] cn;
        logic        ce, is, cs, go, zero;
        string       rtag;
        acc_t        a;
        foreach (mem[i]) sh[i] = mem[i];
        b = base[7:0];
        rtag = "R2";
        go = 1'b1;
        while (go) begin
            w0 = sh[b]; w1 = sh[b + 8'd1]; w2 = sh[b + 8'd2];
            for (int k = 0; k < 3; k++) begin
                a = '{we: 1'b0, wb: 1'b0, addr: {8'h00, b + 8'(k)}, data: 32'h0};
                acc_q.push_back(a); acc_tag_q.push_back(rtag);
            end
            d = sh[w1[7:0]];
            a = '{we: 1'b0, wb: 1'b0, addr: w1[15:0], data: 32'h0};
            acc_q.push_back(a); acc_tag_q.push_back("R2");
            a = '{we: 1'b1, wb: 1'b0, addr: w2[15:0], data: d};
            acc_q.push_back(a); acc_tag_q.push_back("R2");
            sh[w2[7:0]] = d;
            cn = w0[15:0] - 16'd1;
            nw0 = {w0[31:16], cn};
            a = '{we: 1'b1, wb: 1'b1, addr: {8'h00, b}, data: nw0};
            acc_q.push_back(a); acc_tag_q.push_back(tag_force != "" ? tag_force : "R2");
            sh[b] = nw0;
            ce = w0[31]; is = w0[30]; cs = w0[29];
            zero = (cn == 16'd0);
            go = ce && (!cs || zero);
            if (go) begin
                ev_q.push_back(3'b000); ev_tag_q.push_back("R6");
                rtag = cs ? "R5" : "R4";
                b = b + 8'd4;
            end else begin
                ev_q.push_back({!zero && !is, zero || is, zero});
                if (tag_force != "")  ev_tag_q.push_back(tag_force);
                else if (ce && cs)    ev_tag_q.push_back("R5");
                else if (zero)        ev_tag_q.push_back("R8");
                else if (is)          ev_tag_q.push_back("R9");
                else                  ev_tag_q.push_back("R7");
            end
        end
    endtask

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (decide_due) begin
                if (ev_q.size() == 0) begin
                    chk("R12", 1, 0, "pulse cycle with no expected step");
                end else begin
                    logic [2:0] ev;
                    string      t;
                    ev = ev_q.pop_front();
                    t  = ev_tag_q.pop_front();
                    chk(t, {flag_clr, irq_req, en_clr}, ev, "pulses {flag,irq,en}");
                    if (ev != 3'b000) chk("R12", evt_src, exp_src, "evt_src");
                end
                decide_due = 1'b0;
            end else begin
                chk("R12", {flag_clr, irq_req, en_clr}, 3'b000, "pulse outside decide cycle");
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            mem_ready = rdy_rand ? (lfsr[0] | lfsr[1]) : 1'b1;
            if (mem_valid && mem_ready) begin
                if (acc_q.size() == 0) begin
                    chk("R11", {mem_we, mem_addr}, 0, "unexpected access");
                end else begin
                    acc_t  a;
                    string t;
                    a = acc_q.pop_front();
                    t = acc_tag_q.pop_front();
                    chk(t, {mem_we, mem_addr}, {a.we, a.addr}, "access dir/addr");
                    if (a.we) begin
                        chk(t, mem_wdata, a.data, "write data");
                        mem[mem_addr[7:0]] = mem_wdata;
                    end
                    if (a.wb) decide_due = 1'b1;
                end
            end
        end
    end

    task automatic set_slot(input logic [7:0] b, input logic [7:0] mode, input logic [15:0] cnt,
                            input logic [7:0] s, input logic [7:0] d);
        mem[b]        = {mode, 8'h5A, cnt};
        mem[b + 8'd1] = {24'h0, s};
        mem[b + 8'd2] = {24'h0, d};
        mem[b + 8'd3] = 32'h0;
    endtask

    task automatic run(input logic [15:0] base, input logic [3:0] src, input bit poke);
        int n;
        build(base);
        exp_src = src;
        @(negedge clk);
        act_base = base; act_src = src; act_req = 1'b1;
        @(negedge clk);
        act_req = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk);
            act_base = 16'h0010; act_src = 4'hF; act_req = 1'b1;
            @(negedge clk);
            act_req = 1'b0;
        end
        n = 0;
        while ((acc_q.size() != 0 || decide_due || busy) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
        chk("R3", {busy, mem_valid}, 2'b00, "idle after step end");
        chk(poke ? "R11" : "R6", ev_q.size() + acc_q.size(), 0, "model queues drained");
    endtask

    initial begin
        rst_n = 1'b0; act_req = 1'b0; act_src = 4'h0; act_base = 16'h0; mem_ready = 1'b1;
        for (int i = 0; i < 256; i++) mem[i] = 32'hC000_0000 + i * 32'h0001_0203;
        repeat (3) @(negedge clk);
        chk("R1", {busy, mem_valid, flag_clr, irq_req, en_clr}, 5'b0, "outputs in reset");
        rst_n = 1'b1;

        set_slot(8'h10, 8'h00, 16'd5, 8'h80, 8'hA0);
        run(16'h0010, 4'h3, 1'b0);
        chk("R2", mem[8'hA0], mem[8'h80], "destination holds source word");
        chk("R2", mem[8'h10][15:0], 16'd4, "count written back");

        set_slot(8'h14, 8'h40, 16'd3, 8'h81, 8'hA1);
        run(16'h0014, 4'h5, 1'b0);

        set_slot(8'h18, 8'h00, 16'd1, 8'h82, 8'hA2);
        run(16'h0018, 4'h6, 1'b0);
        set_slot(8'h1C, 8'h40, 16'd1, 8'h83, 8'hA3);
        run(16'h001C, 4'h7, 1'b0);

        rdy_rand = 1'b1;
        set_slot(8'h20, 8'h80, 16'd4, 8'h84, 8'hA4);
        set_slot(8'h24, 8'h80, 16'd9, 8'h85, 8'hA5);
        set_slot(8'h28, 8'h00, 16'd2, 8'h86, 8'hA6);
        run(16'h0020, 4'h8, 1'b0);

        set_slot(8'h30, 8'hA0, 16'd7, 8'h87, 8'hA7);
        run(16'h0030, 4'h9, 1'b0);
        set_slot(8'h34, 8'hA0, 16'd1, 8'h88, 8'hA8);
        set_slot(8'h38, 8'h40, 16'd1, 8'h89, 8'hA9);
        run(16'h0034, 4'hA, 1'b0);

        tag_force = "R10";
        set_slot(8'h40, 8'h1F, 16'd9, 8'h8A, 8'hAA);
        run(16'h0040, 4'hB, 1'b0);
        set_slot(8'h44, 8'h9F, 16'd2, 8'h8B, 8'hAB);
        set_slot(8'h48, 8'h00, 16'd3, 8'h8C, 8'hAC);
        run(16'h0044, 4'hC, 1'b0);
        chk("R10", mem[8'h44][31:16], 16'h9F5A, "reserved bits kept on write-back");
        tag_force = "";

        rdy_rand = 1'b0;
        run(16'h0010, 4'hD, 1'b1);
        chk("R11", mem[8'h10][15:0], 16'd3, "one decrement despite second request");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule